// File: doc/BRIEF.md
# Multi-Channel Descriptor Command Sequencer

The block is the command front end for a memory-to-memory processing engine. It has four independent channels. Software sets up a channel by writing a command pointer. It then adds to that channel's semaphore to announce how much work is queued. The sequencer picks a channel that has work, reads the descriptor at the command pointer one 32-bit word at a time through a memory read port, and passes the decoded transfer parameters to the engine with a start pulse. It waits for the engine's done signal. It then updates the channel's semaphore, error status and command pointer, and the shared completion-flag register.

A descriptor can ask for three things at completion: that the semaphore be decremented, that the channel's completion flag be raised, and that the sequencer follow a link to another descriptor. Because of this, one channel can walk a whole chain of descriptors after a single software write. A combined interrupt line reports any raised flag whose channel interrupt is enabled. The cipher and hash datapaths sit outside the block, behind the start/done engine handshake.

The memory request side is valid/ready. `mem_req_valid` stays high and `mem_req_addr` stays unchanged until the cycle in which `mem_req_ready` is high, and only one request is outstanding at a time. The response side has no back-pressure. The memory returns exactly one `mem_rsp_valid` cycle per accepted request, at least one cycle after acceptance. The engine parameters stay stable from the `eng_start` pulse until `eng_done`, and `eng_done` must not be raised in the cycle of `eng_start`.

Top module: `cmdseq_top`

## Requirements
- R1: After reset, all registers read zero. This covers the interrupt enables, the flags, the channel enables, the context pointer, and every command pointer, semaphore and channel status. `irq` and `mem_req_valid` are low.
- R2: Register map, byte offsets on `reg_addr`. Global registers: interrupt enables (low 4 bits) at 0x000, flags at 0x010, flag clear at 0x018, channel enables (low 4 bits) at 0x020, context pointer at 0x050. Channel n's group is at 0x100 + 0x40·n, with the command pointer at +0x00, the semaphore at +0x10, the status at +0x20 and the status clear at +0x28. The context pointer reads back as written and is never used as a fetch address.
- R3: A write to a semaphore adds the written value to its count. The count saturates at 2^SEMA_W−1 (255 by default).
- R4: A fetch issues eight reads, one at a time, at command pointer +0, +4, …, +28. The words are, in order: next address, control 0, control 1, source, destination, size, payload, status.
- R5: After the eighth word, `eng_start` pulses for one cycle. `eng_ctrl0`, `eng_ctrl1`, `eng_src`, `eng_dst`, `eng_size` and `eng_payload` carry words 1, 2, 3, 4, 5 and 6. No further fetch starts until `eng_done`.
- R6: On a successful completion, control 0 bit 1 decrements the channel's semaphore by one, and control 0 bit 0 sets the channel's flag (flag bit n belongs to channel n).
- R7: After a successful completion, if the semaphore is still nonzero and the next address is nonzero, the command pointer takes the next address and the chain continues. Otherwise the command pointer is left unchanged.
- R8: A channel whose enable bit is clear never fetches, whatever its semaphore.
- R9: Channels that are ready are served one descriptor at a time in round-robin order of channel number, starting after the channel served last (channel 0 first after reset).
- R10: A read with `mem_rsp_err` high ends the fetch. It sets the channel status to 1, leaves the semaphore unchanged, sets the channel's flag and halts the channel.
- R11: `eng_err` at `eng_done` sets the channel status to 2, leaves the semaphore unchanged, sets the channel's flag and halts the channel.
- R12: Only a write of 0xFFFFFFFF to the status clear resets a channel status. Any other value is ignored. A halted channel resumes once its status is zero.
- R13: Writing ones to the flag clear (0x018) clears the matching flags. A flag being set in the same cycle wins over the clear.
- R14: `irq` is high exactly when some flag bit and its interrupt-enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Descriptor word byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read failed |
| eng_start | output | 1 | One-cycle engine start |
| eng_ctrl0 | output | 32 | Descriptor control word 0 |
| eng_ctrl1 | output | 32 | Descriptor control word 1 |
| eng_src | output | 32 | Source address |
| eng_dst | output | 32 | Destination address |
| eng_size | output | 32 | Byte count |
| eng_payload | output | 32 | Payload (key or digest) address |
| eng_done | input | 1 | Engine finished the descriptor |
| eng_err | input | 1 | Engine reports an error, valid with `eng_done` |
| irq | output | 1 | Combined completion interrupt |

## Verification
The bench builds the block with its defaults: four channels and an 8-bit semaphore. The 8-bit counter lets two small writes reach the saturation corner. Four channels let round-robin wrap from channel 3 back to 0 and 1 in one test. The memory model drops ready every third cycle to exercise request back-pressure. Reads at or above 0x400 return an error, and an engine size of 0xBAD reports an engine error, so both halting paths and their recovery through the status clear are reachable.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  localparam int DESC_WORDS = 8;
  // descriptor word order as fetched
  localparam int W_NEXT = 0;
  localparam int W_CTRL0 = 1;
  localparam int W_CTRL1 = 2;
  localparam int W_SRC = 3;
  localparam int W_DST = 4;
  localparam int W_SIZE = 5;
  localparam int W_PAYLOAD = 6;
  // control word 0 bits acted on by the sequencer
  localparam int C0_IRQ = 0;
  localparam int C0_DEC = 1;
  // channel status codes
  localparam logic [1:0] CODE_OK = 2'd0;
  localparam logic [1:0] CODE_FETCH = 2'd1;
  localparam logic [1:0] CODE_ENGINE = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_RSP, S_LAUNCH, S_BUSY
  } seq_state_e;
endpackage

// File: rtl/cmdseq_chan.sv
module cmdseq_chan import cmdseq_pkg::*; #(
  parameter int SEMA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_cmd,
  input  logic              wr_sema,
  input  logic              wr_clr,
  input  logic [31:0]       wdata,
  input  logic              fin,
  input  logic [1:0]        fin_code,
  input  logic              fin_dec,
  input  logic [31:0]       fin_next,
  output logic [31:0]       cmdptr,
  output logic [SEMA_W-1:0] count,
  output logic [1:0]        status,
  output logic              pending
);
  localparam logic [33:0] CMAX = {{(34-SEMA_W){1'b0}}, {SEMA_W{1'b1}}};

  logic [31:0] cmd_q;
  logic [SEMA_W-1:0] cnt_q, cnt_nx;
  logic [1:0] st_q;
  logic [33:0] sum;
  logic dec_now, ok_fin, chain_ld, clr_all;

  assign ok_fin  = fin && (fin_code == CODE_OK);
  assign dec_now = ok_fin && fin_dec && (cnt_q != '0);
  assign clr_all = wr_clr && (wdata == 32'hFFFF_FFFF);

  always_comb begin
    sum = {{(34-SEMA_W){1'b0}}, cnt_q}
        + (wr_sema ? {2'b00, wdata} : 34'd0)
        - {33'd0, dec_now};
    cnt_nx = (sum > CMAX) ? CMAX[SEMA_W-1:0] : sum[SEMA_W-1:0];
  end

  assign chain_ld = ok_fin && (fin_next != 32'd0) && (cnt_nx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cnt_q <= '0;
      st_q  <= CODE_OK;
    end else begin
      cnt_q <= cnt_nx;
      if (chain_ld) cmd_q <= fin_next;
      else if (wr_cmd) cmd_q <= wdata;
      if (fin && (fin_code != CODE_OK)) st_q <= fin_code;
      else if (clr_all) st_q <= CODE_OK;
    end
  end

  assign cmdptr  = cmd_q;
  assign count   = cnt_q;
  assign status  = st_q;
  assign pending = en && (cnt_q != '0) && (st_q == CODE_OK);

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < $past(cnt_q)) |-> (cnt_q == $past(cnt_q) - 1'b1));

  assert_status_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_q) != CODE_OK) && !$past(clr_all)) |-> (st_q == $past(st_q)));
endmodule

// File: rtl/cmdseq_arb.sv
module cmdseq_arb #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req,
  input  logic [CH_W-1:0] last,
  output logic            gnt_valid,
  output logic [CH_W-1:0] gnt_ch
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_ch    = '0;
    for (int k = 1; k <= NCH; k++) begin
      if (!gnt_valid && req[(int'(last) + k) % NCH]) begin
        gnt_valid = 1'b1;
        gnt_ch    = CH_W'((int'(last) + k) % NCH);
      end
    end
  end

  assert_grant_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_ch]);
endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm import cmdseq_pkg::*; #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gnt_valid,
  input  logic [CH_W-1:0] gnt_ch,
  input  logic [31:0]     cmdptr_sel,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [31:0]     mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  input  logic            mem_rsp_err,
  output logic            eng_start,
  output logic [31:0]     eng_ctrl0,
  output logic [31:0]     eng_ctrl1,
  output logic [31:0]     eng_src,
  output logic [31:0]     eng_dst,
  output logic [31:0]     eng_size,
  output logic [31:0]     eng_payload,
  input  logic            eng_done,
  input  logic            eng_err,
  output logic            fin,
  output logic [CH_W-1:0] fin_ch,
  output logic [1:0]      fin_code,
  output logic            fin_dec,
  output logic            fin_irq,
  output logic [31:0]     fin_next,
  output logic [CH_W-1:0] last_ch
);
  seq_state_e st_q;
  logic [CH_W-1:0] cur_q, last_q;
  logic [31:0] base_q;
  logic [2:0] idx_q;
  logic [31:0] w_q [DESC_WORDS];

  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_addr  = base_q + {27'd0, idx_q, 2'b00};
  assign eng_start     = (st_q == S_LAUNCH);
  assign eng_ctrl0     = w_q[W_CTRL0];
  assign eng_ctrl1     = w_q[W_CTRL1];
  assign eng_src       = w_q[W_SRC];
  assign eng_dst       = w_q[W_DST];
  assign eng_size      = w_q[W_SIZE];
  assign eng_payload   = w_q[W_PAYLOAD];

  assign fin = ((st_q == S_RSP) && mem_rsp_valid && mem_rsp_err)
            || ((st_q == S_BUSY) && eng_done);
  assign fin_code = (st_q == S_RSP) ? CODE_FETCH : (eng_err ? CODE_ENGINE : CODE_OK);
  assign fin_ch   = cur_q;
  assign fin_dec  = w_q[W_CTRL0][C0_DEC];
  assign fin_irq  = w_q[W_CTRL0][C0_IRQ];
  assign fin_next = w_q[W_NEXT];
  assign last_ch  = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cur_q  <= '0;
      last_q <= CH_W'(NCH - 1);
      base_q <= '0;
      idx_q  <= '0;
      for (int i = 0; i < DESC_WORDS; i++) w_q[i] <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (gnt_valid) begin
          cur_q  <= gnt_ch;
          base_q <= cmdptr_sel;
          idx_q  <= '0;
          st_q   <= S_REQ;
        end
        S_REQ: if (mem_req_ready) st_q <= S_RSP;
        S_RSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            last_q <= cur_q;
            st_q   <= S_IDLE;
          end else begin
            w_q[idx_q] <= mem_rsp_data;
            if (idx_q == 3'd7) st_q <= S_LAUNCH;
            else begin
              idx_q <= idx_q + 3'd1;
              st_q  <= S_REQ;
            end
          end
        end
        S_LAUNCH: st_q <= S_BUSY;
        S_BUSY: if (eng_done) begin
          last_q <= cur_q;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_no_fetch_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !mem_req_valid);
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top import cmdseq_pkg::*; #(
  parameter int NCH    = 4,   // at most 4: channel groups fill 0x100..0x1FF
  parameter int SEMA_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        eng_start,
  output logic [31:0] eng_ctrl0,
  output logic [31:0] eng_ctrl1,
  output logic [31:0] eng_src,
  output logic [31:0] eng_dst,
  output logic [31:0] eng_size,
  output logic [31:0] eng_payload,
  input  logic        eng_done,
  input  logic        eng_err,
  output logic        irq
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] ie_q, en_q, flag_q, flag_set, pend;
  logic [31:0] ctx_q;
  logic wr_ie, wr_fclr, wr_en, wr_ctx;

  logic [31:0]       cp_a  [NCH];
  logic [SEMA_W-1:0] cnt_a [NCH];
  logic [1:0]        st_a  [NCH];

  logic            gnt_valid, fin, fin_dec, fin_irq;
  logic [CH_W-1:0] gnt_ch, fin_ch, last_ch;
  logic [1:0]      fin_code;
  logic [31:0]     fin_next;

  assign wr_ie   = reg_wr_en && (reg_addr == 12'h000);
  assign wr_fclr = reg_wr_en && (reg_addr == 12'h018);
  assign wr_en   = reg_wr_en && (reg_addr == 12'h020);
  assign wr_ctx  = reg_wr_en && (reg_addr == 12'h050);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic in_grp;
    assign in_grp = reg_wr_en && (reg_addr[11:8] == 4'h1) && (reg_addr[7:6] == 2'(c));
    cmdseq_chan #(.SEMA_W(SEMA_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q[c]),
      .wr_cmd   (in_grp && (reg_addr[5:0] == 6'h00)),
      .wr_sema  (in_grp && (reg_addr[5:0] == 6'h10)),
      .wr_clr   (in_grp && (reg_addr[5:0] == 6'h28)),
      .wdata    (reg_wdata),
      .fin      (fin && (fin_ch == CH_W'(c))),
      .fin_code (fin_code),
      .fin_dec  (fin_dec),
      .fin_next (fin_next),
      .cmdptr   (cp_a[c]),
      .count    (cnt_a[c]),
      .status   (st_a[c]),
      .pending  (pend[c])
    );
  end

  cmdseq_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (pend),
    .last      (last_ch),
    .gnt_valid (gnt_valid),
    .gnt_ch    (gnt_ch)
  );

  cmdseq_fsm #(.NCH(NCH), .CH_W(CH_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .gnt_valid     (gnt_valid),
    .gnt_ch        (gnt_ch),
    .cmdptr_sel    (cp_a[gnt_ch]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err),
    .eng_start     (eng_start),
    .eng_ctrl0     (eng_ctrl0),
    .eng_ctrl1     (eng_ctrl1),
    .eng_src       (eng_src),
    .eng_dst       (eng_dst),
    .eng_size      (eng_size),
    .eng_payload   (eng_payload),
    .eng_done      (eng_done),
    .eng_err       (eng_err),
    .fin           (fin),
    .fin_ch        (fin_ch),
    .fin_code      (fin_code),
    .fin_dec       (fin_dec),
    .fin_irq       (fin_irq),
    .fin_next      (fin_next),
    .last_ch       (last_ch)
  );

  always_comb begin
    flag_set = '0;
    if (fin && (fin_irq || (fin_code != CODE_OK))) flag_set[fin_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= '0;
      en_q   <= '0;
      flag_q <= '0;
      ctx_q  <= '0;
    end else begin
      if (wr_ie)  ie_q  <= reg_wdata[NCH-1:0];
      if (wr_en)  en_q  <= reg_wdata[NCH-1:0];
      if (wr_ctx) ctx_q <= reg_wdata;
      flag_q <= (flag_q & ~(wr_fclr ? reg_wdata[NCH-1:0] : {NCH{1'b0}})) | flag_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      12'h000: reg_rdata[NCH-1:0] = ie_q;
      12'h010: reg_rdata[NCH-1:0] = flag_q;
      12'h020: reg_rdata[NCH-1:0] = en_q;
      12'h050: reg_rdata = ctx_q;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if ((reg_addr[11:8] == 4'h1) && (reg_addr[7:6] == 2'(c))) begin
        case (reg_addr[5:0])
          6'h00: reg_rdata = cp_a[c];
          6'h10: reg_rdata = 32'(cnt_a[c]);
          6'h20: reg_rdata = 32'(st_a[c]);
          default: ;
        endcase
      end
    end
  end

  assign irq = |(flag_q & ie_q);

  assert_flag_from_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) != '0) |-> $past(fin));
endmodule

// File: tb/sim_cmdseq_top.sv
module sim_cmdseq_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        reg_wr_en;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_err;
  logic [31:0] mem_rsp_data;
  logic        eng_start, eng_done, eng_err;
  logic [31:0] eng_ctrl0, eng_ctrl1, eng_src, eng_dst, eng_size, eng_payload;
  logic        irq;

  cmdseq_top u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // memory model: ready low every third cycle, response one cycle after accept
  logic [31:0] mem [256];
  bit rsp_pend = 0;
  logic [31:0] rsp_addr = '0, last_req = '0;
  int bp = 0, n_req = 0, ctx_hits = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 0; mem_rsp_err = 0; mem_rsp_data = '0;
      mem_req_ready = 0; rsp_pend = 0;
    end else begin
      mem_rsp_valid = 0; mem_rsp_err = 0;
      if (rsp_pend) begin
        mem_rsp_valid = 1;
        if (rsp_addr < 32'h400) mem_rsp_data = mem[rsp_addr[9:2]];
        else begin mem_rsp_err = 1; mem_rsp_data = 32'hDEAD_DEAD; end
        rsp_pend = 0;
      end
      bp++;
      mem_req_ready = (bp % 3) != 1;
      if (mem_req_valid && mem_req_ready) begin
        rsp_pend = 1; rsp_addr = mem_req_addr; last_req = mem_req_addr; n_req++;
        if (mem_req_addr >= 32'hFFFF_0000) ctx_hits++;
      end
    end
  end

  // engine stub: done three cycles after start, error when size is 0xBAD
  int eng_cnt = 0, n_start = 0;
  logic [31:0] src_log [32];
  logic [31:0] last_c0 = '0, last_src = '0;
  always @(negedge clk) begin
    eng_done = 0; eng_err = 0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin eng_done = 1; eng_err = (eng_size == 32'hBAD); end
    end
    if (rst_n && eng_start) begin
      src_log[n_start % 32] = eng_src;
      last_c0 = eng_ctrl0; last_src = eng_src;
      n_start++; eng_cnt = 3;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr_en = 1;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] cb(input int c);
    return 12'h100 + 12'(c * 64);
  endfunction

  task automatic put_desc(input int a, input logic [31:0] nxt, input logic [31:0] c0,
                          input logic [31:0] src, input logic [31:0] sz);
    mem[(a >> 2) + 0] = nxt;      mem[(a >> 2) + 1] = c0;
    mem[(a >> 2) + 2] = 32'h0;    mem[(a >> 2) + 3] = src;
    mem[(a >> 2) + 4] = src + 32'h100; mem[(a >> 2) + 5] = sz;
    mem[(a >> 2) + 6] = 32'h0;    mem[(a >> 2) + 7] = 32'h0;
  endtask

  // vector: {channel[1:0], control0[15:0], expected flag}
  localparam logic [18:0] VEC [6] = '{
    {2'd0, 16'h0003, 1'b1}, {2'd1, 16'h1062, 1'b0}, {2'd2, 16'h0323, 1'b1},
    {2'd3, 16'h2843, 1'b1}, {2'd0, 16'h0002, 1'b0}, {2'd2, 16'h3043, 1'b1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (R1..all) actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int s0, q0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    rst_n = 0; reg_wr_en = 0; reg_addr = '0; reg_wdata = '0;
    idle(5); rst_n = 1; idle(2);

    // R1 reset state
    rd(12'h010, r); check("R1 flags", r, 0);
    rd(12'h020, r); check("R1 enables", r, 0);
    rd(12'h050, r); check("R1 context", r, 0);
    rd(cb(0), r); check("R1 cmdptr0", r, 0);
    rd(cb(3) + 12'h10, r); check("R1 sema3", r, 0);
    rd(cb(2) + 12'h20, r); check("R1 status2", r, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 req", {31'd0, mem_req_valid}, 0);

    wr(12'h000, 32'hF); wr(12'h020, 32'hF); wr(12'h050, 32'hFFFF_0000);

    // vector table
    for (int i = 0; i < 6; i++) begin
      int ch; logic [15:0] c0; logic fl; int da;
      ch = int'(VEC[i][18:17]); c0 = VEC[i][16:1]; fl = VEC[i][0];
      da = 32'h40 * (i + 1);
      wr(12'h018, 32'hFFFF_FFFF);
      put_desc(da, 32'h0, {16'h0, c0}, 32'h2000 + i, 32'h10 + i);
      s0 = n_start; q0 = n_req;
      wr(cb(ch), da); wr(cb(ch) + 12'h10, 1);
      idle(80);
      check("R4 eight reads", n_req - q0, 8);
      check("R4 last read addr", last_req, da + 28);
      check("R5 one launch", n_start - s0, 1);
      check("R5 src", last_src, 32'h2000 + i);
      check("R5 ctrl0", last_c0, {16'h0, c0});
      rd(cb(ch) + 12'h10, r); check("R6 sema decremented", r, 0);
      rd(12'h010, r); check("R6 flag", r, {28'd0, 4'(fl) << ch});
      #1; check("R14 irq follows flag", {31'd0, irq}, {31'd0, fl});
    end

    // R8 disabled channels, then R9 round-robin (last served: channel 2)
    wr(12'h020, 0);
    put_desc(32'h380, 0, 32'h2, 32'hA0, 32'h8);
    put_desc(32'h3A0, 0, 32'h2, 32'hA1, 32'h8);
    put_desc(32'h3C0, 0, 32'h2, 32'hA3, 32'h8);
    wr(cb(0), 32'h380); wr(cb(1), 32'h3A0); wr(cb(3), 32'h3C0);
    wr(cb(0) + 12'h10, 1); wr(cb(1) + 12'h10, 1); wr(cb(3) + 12'h10, 1);
    s0 = n_start; q0 = n_req;
    idle(80);
    check("R8 no launch while disabled", n_start - s0, 0);
    check("R8 no reads while disabled", n_req - q0, 0);
    rd(cb(1) + 12'h10, r); check("R8 sema kept", r, 1);
    wr(12'h020, 32'hF);
    idle(200);
    check("R9 three launches", n_start - s0, 3);
    check("R9 first ch3", src_log[s0 % 32], 32'hA3);
    check("R9 then ch0", src_log[(s0 + 1) % 32], 32'hA0);
    check("R9 then ch1", src_log[(s0 + 2) % 32], 32'hA1);

    // R7 chain of two on channel 1
    put_desc(32'h200, 32'h240, 32'h2, 32'hB0, 32'h8);
    put_desc(32'h240, 32'h0, 32'h3, 32'hB1, 32'h8);
    wr(12'h018, 32'hFFFF_FFFF);
    s0 = n_start;
    wr(cb(1), 32'h200); wr(cb(1) + 12'h10, 2);
    idle(160);
    check("R7 chain launches", n_start - s0, 2);
    check("R7 chain order a", src_log[s0 % 32], 32'hB0);
    check("R7 chain order b", src_log[(s0 + 1) % 32], 32'hB1);
    rd(cb(1), r); check("R7 cmdptr followed link", r, 32'h240);
    rd(cb(1) + 12'h10, r); check("R6 chain sema", r, 0);
    rd(12'h010, r); check("R6 flag only from last", r, 32'h2);

    // R7 chain stops when the semaphore runs out
    put_desc(32'h280, 32'h2C0, 32'h2, 32'hC0, 32'h8);
    put_desc(32'h2C0, 32'h0, 32'h3, 32'hC1, 32'h8);
    s0 = n_start;
    wr(cb(1), 32'h280); wr(cb(1) + 12'h10, 1);
    idle(100);
    check("R7 single launch", n_start - s0, 1);
    check("R7 ran first only", last_src, 32'hC0);
    rd(cb(1), r); check("R7 cmdptr kept", r, 32'h280);

    // R10 fetch error on channel 3, R12 clear rules
    wr(12'h018, 32'hFFFF_FFFF);
    s0 = n_start; q0 = n_req;
    wr(cb(3), 32'h1000); wr(cb(3) + 12'h10, 1);
    idle(100);
    rd(cb(3) + 12'h20, r); check("R10 status fetch error", r, 1);
    rd(cb(3) + 12'h10, r); check("R10 sema kept", r, 1);
    check("R10 no launch", n_start - s0, 0);
    check("R10 halted after one read", n_req - q0, 1);
    rd(12'h010, r); check("R10 flag", r, 32'h8);
    wr(cb(3) + 12'h28, 32'h1234_5678);
    rd(cb(3) + 12'h20, r); check("R12 partial clear ignored", r, 1);
    put_desc(32'h300, 0, 32'h3, 32'hD0, 32'h8);
    wr(cb(3), 32'h300); wr(cb(3) + 12'h28, 32'hFFFF_FFFF);
    idle(80);
    rd(cb(3) + 12'h20, r); check("R12 status cleared", r, 0);
    rd(cb(3) + 12'h10, r); check("R12 resumed sema", r, 0);
    check("R12 resumed launch", n_start - s0, 1);

    // R11 engine error on channel 0
    put_desc(32'h340, 0, 32'h3, 32'hE0, 32'hBAD);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(cb(0), 32'h340); wr(cb(0) + 12'h10, 1);
    idle(80);
    rd(cb(0) + 12'h20, r); check("R11 status engine error", r, 2);
    rd(cb(0) + 12'h10, r); check("R11 sema kept", r, 1);
    rd(12'h010, r); check("R11 flag", r, 32'h1);
    mem[(32'h340 >> 2) + 5] = 32'h20;
    wr(cb(0) + 12'h28, 32'hFFFF_FFFF);
    idle(80);
    rd(cb(0) + 12'h10, r); check("R11 retry sema", r, 0);

    // R14 interrupt masking, R13 flag clear
    wr(12'h000, 32'hE); #1; check("R14 masked", {31'd0, irq}, 0);
    wr(12'h000, 32'hF); #1; check("R14 unmasked", {31'd0, irq}, 1);
    wr(12'h018, 32'h1);
    rd(12'h010, r); check("R13 flag cleared", r, 0);
    check("R13 irq dropped", {31'd0, irq}, 0);

    // R2 map readback and unused context pointer
    wr(cb(2), 32'h1234_5670);
    rd(cb(2), r); check("R2 cmdptr readback", r, 32'h1234_5670);
    rd(12'h050, r); check("R2 context readback", r, 32'hFFFF_0000);
    rd(12'h000, r); check("R2 enables readback", r, 32'hF);
    check("R2 context never fetched", ctx_hits, 0);

    // R3 semaphore add and saturation
    wr(12'h020, 0);
    wr(cb(3) + 12'h10, 3); wr(cb(3) + 12'h10, 4);
    rd(cb(3) + 12'h10, r); check("R3 add", r, 7);
    wr(cb(2) + 12'h10, 200); wr(cb(2) + 12'h10, 100);
    rd(cb(2) + 12'h10, r); check("R3 saturate", r, 255);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule